// File: doc/BRIEF.md
# Third-Order Sinc Decimator for a One-Bit Modulator Stream

This block turns the single-bit output of an external sigma-delta modulator into decimated two's-complement samples. The same clock that drives the modulator also samples its bitstream, so one bit enters on every clock edge. Three wrap-around integrators run on every bit. Three differentiators run once per decimation period. A programmable ratio sets the length of that period. A midpoint offset is removed so that a half-density stream gives a result of zero.

The result is presented in one of two ways. The full-width result can sit in the upper part of a 32-bit word. It can also be arithmetically shifted right by a programmable amount and presented as a sign-extended 16-bit value. A filter runs only while both its own enable and a shared master enable are high. Raising the master enable last lets several instances begin their decimation periods on the same edge. A one-cycle strobe marks every new sample, and a settled flag marks samples whose history is complete.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is asserted and on the first edge after it, `data_out` is 0, `data_vld` is 0 and `settled` is 0.
- R2: A bit of 1 counts as 1 and a bit of 0 counts as 0. The result equals the third-order sinc sum over the bits since the run began, minus floor(OSR^3/2). For a stream with a period that divides OSR, holding k ones in every OSR bits, the result once settled is k*OSR^2 - floor(OSR^3/2).
- R3: `osr_m1` holds the ratio minus one, so 255 gives OSR 256. A value of 0 is treated as 1, giving OSR 2. While running, `data_vld` pulses once every OSR clock edges.
- R4: The decimation phase starts at the first edge on which both enables are high. The first strobe follows exactly OSR edges later, no matter which enable rose last.
- R5: While `master_en` is low, no strobe occurs and `data_out` holds, whatever the state of `filt_en`.
- R6: While `filt_en` is low, no strobe occurs and `data_out` holds. All filter state is cleared, so the next run starts from a fresh phase and an empty history.
- R7: With `rep_sel` = 1 (32-bit format), `data_out[31:7]` holds the 25-bit result and `data_out[6:0]` is 0.
- R8: With `rep_sel` = 0 (16-bit format), `data_out[15:0]` is bits 15..0 of the result arithmetically shifted right by `shift_amt`, and `data_out[31:16]` copies `data_out[15]`.
- R9: `settled` is 0 on the first three samples after a run starts, 1 on every later sample, and 0 while not running. It rises only together with a strobe.
- R10: `data_vld` is high for one cycle at a time, never on two edges in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock; also samples the bitstream |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_bit | input | 1 | One-bit modulator output |
| master_en | input | 1 | Shared run permission for all instances |
| filt_en | input | 1 | Enable for this filter |
| osr_m1 | input | 8 | Decimation ratio minus one |
| rep_sel | input | 1 | 1: full result in upper bits, 0: shifted 16-bit |
| shift_amt | input | 5 | Right shift applied in 16-bit format |
| data_out | output | 32 | Last decimated sample |
| data_vld | output | 1 | One-cycle strobe on each new sample |
| settled | output | 1 | Sample has a full filter history |

## Verification
A sample is written on the OSR-th edge after the run starts, counting the edge on which both enables are first seen high. It is visible on `data_out` with `data_vld` and `settled` right after that edge, through one register. The bench drives inputs and samples outputs on falling edges. It numbers the edges from the enabling one and requires the n-th strobe exactly at edge n*OSR. Value checks wait for the fifth sample, so the bench's closed-form result for a periodic stream applies without modelling the pipeline fill. The stop, hold and restart cases are checked on every cycle of the stopped interval.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
    localparam int ORDER = 3;
    typedef enum logic {REP_16 = 1'b0, REP_32 = 1'b1} rep_e;
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ
    import sinc3_pkg::*;
#(
    parameter int ACC_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bit_in,
    output logic [ACC_W-1:0] last
);
    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic [ORDER-1:0][ACC_W-1:0] feed;

    // stage 0 takes the bit, later stages take the previous accumulator
    assign feed[0] = {{(ACC_W-1){1'b0}}, bit_in};
    for (genvar g = 1; g < ORDER; g++) begin : g_feed
        assign feed[g] = st_q.acc[g-1];
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < ORDER; k++) begin
            if (!run) st_d.acc[k] = '0;
            else      st_d.acc[k] = st_q.acc[k] + feed[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last = st_q.acc[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
    import sinc3_pkg::*;
#(
    parameter int OSR_W = 8,
    parameter int ACC_W = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [OSR_W-1:0]        osr_m1,
    input  logic [ACC_W-1:0]        integ_in,
    output logic                    fire,
    output logic signed [ACC_W-1:0] result
);
    typedef struct packed {
        logic [OSR_W-1:0]            cnt;
        logic [ORDER-1:0][ACC_W-1:0] z;
    } st_t;

    st_t st_d, st_q;
    logic [OSR_W-1:0]            m1_eff;
    logic [ACC_W-1:0]            osr_ext;
    logic [ACC_W-1:0]            cube;
    logic [ORDER-1:0][ACC_W-1:0] dif;
    logic [ORDER-1:0][ACC_W-1:0] zin;

    assign m1_eff  = (osr_m1 == '0) ? OSR_W'(1) : osr_m1;
    assign osr_ext = ACC_W'(m1_eff) + ACC_W'(1);

    assign dif[0] = integ_in - st_q.z[0];
    assign zin[0] = integ_in;
    for (genvar g = 1; g < ORDER; g++) begin : g_diff
        assign dif[g] = dif[g-1] - st_q.z[g];
        assign zin[g] = dif[g-1];
    end

    always_comb begin
        cube = ACC_W'(1);
        for (int k = 0; k < ORDER; k++) cube = ACC_W'(cube * osr_ext);
    end

    assign fire   = run && (st_q.cnt == m1_eff);
    assign result = signed'(dif[ORDER-1] - (cube >> 1));

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (fire) begin
            st_d.cnt = '0;
            st_d.z   = zin;
        end else begin
            st_d.cnt = st_q.cnt + OSR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int OSR_W  = 8,
    parameter int SH_W   = 5,
    parameter int DOUT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_bit,
    input  logic              master_en,
    input  logic              filt_en,
    input  logic [OSR_W-1:0]  osr_m1,
    input  logic              rep_sel,
    input  logic [SH_W-1:0]   shift_amt,
    output logic [DOUT_W-1:0] data_out,
    output logic              data_vld,
    output logic              settled
);
    localparam int ACC_W = ORDER * OSR_W + 1;
    localparam int PAD   = DOUT_W - ACC_W;
    localparam int HALF  = DOUT_W / 2;
    localparam int NC_W  = $clog2(ORDER + 1);

    typedef struct packed {
        logic [DOUT_W-1:0] data;
        logic              vld;
        logic [NC_W-1:0]   nout;
        logic              settled;
    } st_t;

    st_t st_d, st_q;
    logic                    run;
    logic [ACC_W-1:0]        integ_last;
    logic                    fire;
    logic signed [ACC_W-1:0] res;
    logic signed [ACC_W-1:0] res_sh;
    logic [DOUT_W-1:0]       word;

    assign run = master_en && filt_en;

    sinc3_integ #(.ACC_W(ACC_W)) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .bit_in (mod_bit),
        .last   (integ_last)
    );

    sinc3_comb #(.OSR_W(OSR_W), .ACC_W(ACC_W)) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .osr_m1   (osr_m1),
        .integ_in (integ_last),
        .fire     (fire),
        .result   (res)
    );

    assign res_sh = res >>> shift_amt;

    always_comb begin
        if (rep_e'(rep_sel) == REP_32) word = {res, {PAD{1'b0}}};
        else                           word = {{HALF{res_sh[HALF-1]}}, res_sh[HALF-1:0]};
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = fire;
        if (!run) begin
            st_d.nout    = '0;
            st_d.settled = 1'b0;
        end else if (fire) begin
            st_d.data    = word;
            st_d.settled = (st_q.nout == NC_W'(ORDER));
            if (st_q.nout != NC_W'(ORDER)) st_d.nout = st_q.nout + NC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_out = st_q.data;
    assign data_vld = st_q.vld;
    assign settled  = st_q.settled;
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
    parameter int OSR_W  = 8,
    parameter int SH_W   = 5,
    parameter int DOUT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mod_bit,
    input logic              master_en,
    input logic              filt_en,
    input logic [OSR_W-1:0]  osr_m1,
    input logic              rep_sel,
    input logic [SH_W-1:0]   shift_amt,
    input logic [DOUT_W-1:0] data_out,
    input logic              data_vld,
    input logic              settled
);
    localparam int ACC_W = 3 * OSR_W + 1;
    localparam int PAD   = DOUT_W - ACC_W;
    localparam int HALF  = DOUT_W / 2;

    AST_MASTER_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !data_vld && $stable(data_out)); // R5

    AST_FILT_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |=> !data_vld && $stable(data_out)); // R6

    AST_WIDE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld && $past(rep_sel) |-> data_out[PAD-1:0] == '0); // R7

    AST_NARROW_SIGNEXT: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld && !$past(rep_sel) |-> data_out[DOUT_W-1:HALF] == {HALF{data_out[HALF-1]}}); // R8

    AST_SETTLE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> data_vld); // R9

    AST_SETTLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(master_en && filt_en) |=> !settled); // R9

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |=> !data_vld); // R10
endmodule

bind sinc3_decim sinc3_decim_chk #(.OSR_W(OSR_W), .SH_W(SH_W), .DOUT_W(DOUT_W)) u_chk (.*);

// File: tb/sinc3_decim_test.sv
`timescale 1ns/1ps
module sinc3_decim_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_bit = 1'b0;
    logic        master_en = 1'b0;
    logic        filt_en = 1'b0;
    logic [7:0]  osr_m1 = 8'd3;
    logic        rep_sel = 1'b0;
    logic [4:0]  shift_amt = 5'd0;
    logic [31:0] data_out;
    logic        data_vld;
    logic        settled;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int pc    = 0;
    int ptype = 0;

    always #10 clk = ~clk;

    sinc3_decim uut (
        .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .master_en(master_en),
        .filt_en(filt_en), .osr_m1(osr_m1), .rep_sel(rep_sel), .shift_amt(shift_amt),
        .data_out(data_out), .data_vld(data_vld), .settled(settled)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic pat(input int t, input int p);
        case (t)
            0: pat = 1'b0;
            1: pat = 1'b1;
            2: pat = p[0];
            3: pat = (p[1:0] == 2'd0);
            default: pat = (p[1:0] != 2'd0);
        endcase
    endfunction

    task automatic drive_bit();
        mod_bit = pat(ptype, pc);
        pc++;
    endtask

    task automatic run_cfg(input int osr, input int t, input bit r32);
        int lg, sh, k, full, idx;
        logic [31:0] exp, tsh;
        lg = $clog2(osr);
        sh = (3 * lg + 1 > 16) ? 3 * lg + 1 - 16 : 0;
        case (t)
            0: k = 0;
            1: k = osr;
            2: k = osr / 2;
            3: k = osr / 4;
            default: k = 3 * osr / 4;
        endcase
        full = k * osr * osr - (osr * osr * osr) / 2;
        if (r32) exp = 32'(full) << 7;
        else begin
            tsh = 32'(full >>> sh);
            exp = {{16{tsh[15]}}, tsh[15:0]};
        end
        @(negedge clk);
        filt_en = 1'b0; osr_m1 = 8'(osr - 1); rep_sel = r32; shift_amt = 5'(sh);
        ptype = t;
        @(negedge clk);
        @(negedge clk);
        chk(!data_vld && !settled, "R6 idle before run", {30'd0, data_vld, settled}, 32'd0);
        filt_en = 1'b1;
        drive_bit();
        idx = 0;
        for (int j = 1; j <= 8 * osr + 2; j++) begin
            @(negedge clk);
            if (data_vld) begin
                chk(j == (idx + 1) * osr, "R3/R4 strobe edge", 32'(j), 32'((idx + 1) * osr));
                chk(settled == (idx >= 3), "R9 settled flag", {31'd0, settled}, {31'd0, idx >= 3});
                if (idx >= 4)
                    chk(data_out == exp, r32 ? "R2/R7 wide value" : "R2/R8 narrow value", data_out, exp);
                idx++;
            end
            drive_bit();
        end
        chk(idx == 8, "R10 strobe count", 32'(idx), 32'd8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        int cnt, first;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(data_out == 0 && !data_vld && !settled, "R1 in reset", data_out, 32'd0);
        rst_n = 1'b1;
        master_en = 1'b1; filt_en = 1'b1;
        @(negedge clk);
        chk(data_out == 0 && !data_vld && !settled, "R1 after reset", data_out, 32'd0);

        // R2 R3 R4 R7 R8 R9 R10 sweep
        for (int o = 0; o < 4; o++)
            for (int t = 0; t < 5; t++)
                run_cfg(4 << (2 * o), t, ((o + t) % 2) == 1);

        // R3 ratio field 0 acts as OSR 2
        @(negedge clk); filt_en = 1'b0; osr_m1 = 8'd0;
        @(negedge clk); filt_en = 1'b1;
        cnt = 0; first = 0;
        for (int j = 1; j <= 20; j++) begin
            @(negedge clk);
            if (data_vld) begin
                cnt++;
                if (first == 0) first = j;
            end
        end
        chk(cnt == 10, "R3 field zero rate", 32'(cnt), 32'd10);
        chk(first == 2, "R3 field zero first", 32'(first), 32'd2);

        // R5 master low blocks and holds; master last gives aligned start
        @(negedge clk); filt_en = 1'b0; master_en = 1'b0; osr_m1 = 8'd15; ptype = 1; rep_sel = 1'b1;
        @(negedge clk); filt_en = 1'b1;
        held = data_out;
        for (int j = 0; j < 100; j++) begin
            @(negedge clk);
            if (data_vld || data_out != held) chk(0, "R5 master low", data_out, held);
            drive_bit();
        end
        chk(data_out == held, "R5 held value", data_out, held);
        master_en = 1'b1;
        first = 0;
        for (int j = 1; j <= 40; j++) begin
            @(negedge clk);
            if (data_vld && first == 0) first = j;
            drive_bit();
        end
        chk(first == 16, "R4 master last start", 32'(first), 32'd16);

        // R6 stop mid-run, hold, restart fresh
        repeat (100) begin @(negedge clk); drive_bit(); end
        filt_en = 1'b0;
        @(negedge clk);
        held = data_out;
        for (int j = 0; j < 50; j++) begin
            @(negedge clk);
            if (data_vld || data_out != held || settled) chk(0, "R6/R9 stopped", data_out, held);
        end
        chk(data_out == held && !settled, "R6 hold after stop", data_out, held);
        filt_en = 1'b1;
        first = 0;
        for (int j = 1; j <= 20; j++) begin
            @(negedge clk);
            if (data_vld && first == 0) begin
                first = j;
                chk(!settled, "R9 restart unsettled", {31'd0, settled}, 32'd0);
            end
            drive_bit();
        end
        chk(first == 16, "R6 fresh phase", 32'(first), 32'd16);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule